// File: doc/BRIEF.md
# Quadrature Sign-Sign LMS Interference Canceller

This block is the digital adaptation core that removes a 60 Hz common-mode tone leaking into the output of a differential front-end amplifier. It does not sample the interferer. Instead it rebuilds a copy of it from the stream of level-shift events that the common-mode suppression circuit applies. Every event moves an up/down counter one step. The sign of that counter is the in-phase reference. A delay line holding a quarter of the interferer period turns it into the quadrature reference.

On every sample pulse, two independent sign-sign LMS weights are updated. Each one adds the product of its own 1-bit reference and the 1-bit sign of the amplifier output. Together the two weights track both the gain and the phase of the leaked tone. Each weight is a signed value held inside ±(2^(WEIGHT_W-1)-1). It is presented as a thermometer code for a unit-element capacitor DAC, plus a sign bit. The sign bit is combined with the live common-mode shift control to set the polarity of the corrective differential shift on each path.

Top module: `qsslms_canceller`

## Requirements
- R1: While `rst` is high at a clock edge, both weights, both thermometer codes, both sign bits and both reference outputs go to zero.
- R2: Each cycle with `shift_evt` high moves the reconstruction counter one step up (`shift_up`=1) or down (`shift_up`=0), clamped to the signed REF_W-bit range. `ref_i_neg` is 1 exactly when the counter is negative.
- R3: `ref_q_neg` equals the value `ref_i_neg` had at the sample pulse DELAY_LEN pulses earlier, where DELAY_LEN = SAMPLE_RATE/240. It is 0 until that many pulses have occurred after reset.
- R4: On a cycle with `sample_en` and `enable` both high, `w_i` rises by one when `ref_i_neg` equals `out_neg`, and falls by one otherwise.
- R5: `w_q` follows the same rule using `ref_q_neg` in place of `ref_i_neg`, independently of `w_i`.
- R6: Each weight saturates at +WMAX and -WMAX, where WMAX = 2^(WEIGHT_W-1)-1. An update that would leave that range leaves the weight unchanged.
- R7: While `enable` is low, sample pulses leave both weights unchanged.
- R8: Cycles without `sample_en` leave both weights unchanged, whatever `out_neg`, `shift_evt` and `cm_shift` do.
- R9: `therm_x` has its lowest |w_x| bits set and all others clear. `sign_x` is 1 exactly when w_x is negative.
- R10: `dm_shift_x` equals `cm_shift` XOR `sign_x`, so a negative weight inverts the corrective shift polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Adaptation enable; low freezes both weights |
| sample_en | input | 1 | One-cycle pulse per output sample |
| shift_evt | input | 1 | Common-mode level-shift event strobe |
| shift_up | input | 1 | Direction of the event (1 = up) |
| cm_shift | input | 1 | Live common-mode shift control level |
| out_neg | input | 1 | Amplifier output sign (1 = negative) |
| ref_i_neg | output | 1 | In-phase reference sign |
| ref_q_neg | output | 1 | Quadrature reference sign |
| w_i | output | WEIGHT_W | In-phase weight, signed |
| w_q | output | WEIGHT_W | Quadrature weight, signed |
| therm_i | output | WMAX | In-phase DAC thermometer code |
| therm_q | output | WMAX | Quadrature DAC thermometer code |
| sign_i | output | 1 | In-phase weight sign |
| sign_q | output | 1 | Quadrature weight sign |
| dm_shift_i | output | 1 | In-phase corrective shift polarity |
| dm_shift_q | output | 1 | Quadrature corrective shift polarity |

## Verification
The bench builds the block with WEIGHT_W=5, REF_W=4 and SAMPLE_RATE=960. That gives a weight range of ±15 with 15-bit thermometer codes, a reference counter clamped to -8..7, and a four-sample quarter-period delay. At these values a few dozen sample pulses drive both weights into positive and negative saturation. A handful of shift events hits both clamp limits of the counter. The quadrature output can be compared against a fully filled delay line, so every boundary the requirements name is reached within a short run.

// File: rtl/qsslms_pkg.sv
`timescale 1ns/1ps
package qsslms_pkg;
   // samples per quarter period of a 60 Hz tone = rate / (4 * 60)
   localparam int QUARTER_DIV = 240;

   function automatic int quarter_len(input int rate);
      return rate / QUARTER_DIV;
   endfunction

   function automatic int weight_limit(input int width);
      return (1 << (width - 1)) - 1;
   endfunction
endpackage

// File: rtl/qs_ref_track.sv
`timescale 1ns/1ps
module qs_ref_track #(
   parameter int REF_W = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic shift_evt,
   input  logic shift_up,
   output logic ref_neg
);
   localparam logic signed [REF_W-1:0] CNT_MAX = {1'b0, {(REF_W-1){1'b1}}};
   localparam logic signed [REF_W-1:0] CNT_MIN = {1'b1, {(REF_W-1){1'b0}}};
   localparam logic signed [REF_W-1:0] STEP    = REF_W'(1);

   logic signed [REF_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (shift_evt) begin
         if (shift_up) begin
            if (cnt != CNT_MAX) cnt <= cnt + STEP;
         end else begin
            if (cnt != CNT_MIN) cnt <= cnt - STEP;
         end
      end
   end

   assign ref_neg = cnt[REF_W-1];

   p_idle_r2: assert property (@(posedge clk) disable iff (rst)
      !shift_evt |=> $stable(cnt));
   p_up_r2: assert property (@(posedge clk) disable iff (rst)
      (shift_evt && shift_up && cnt != CNT_MAX) |=> (cnt == $past(cnt) + STEP));
   p_down_r2: assert property (@(posedge clk) disable iff (rst)
      (shift_evt && !shift_up && cnt != CNT_MIN) |=> (cnt == $past(cnt) - STEP));
endmodule

// File: rtl/qs_quarter_delay.sv
`timescale 1ns/1ps
module qs_quarter_delay #(
   parameter int LEN = 10
) (
   input  logic clk,
   input  logic rst,
   input  logic sample_en,
   input  logic din,
   output logic dout
);
   logic [LEN-1:0] line;

   generate
      if (LEN == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst)            line <= '0;
            else if (sample_en) line <= din;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (rst)            line <= '0;
            else if (sample_en) line <= {line[LEN-2:0], din};
         end
      end
   endgenerate

   assign dout = line[LEN-1];

   p_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !sample_en |=> $stable(dout));
endmodule

// File: rtl/qs_sign_weight.sv
`timescale 1ns/1ps
module qs_sign_weight #(
   parameter int WEIGHT_W = 10
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       upd,
   input  logic                       ref_neg,
   input  logic                       err_neg,
   output logic signed [WEIGHT_W-1:0] w
);
   localparam logic signed [WEIGHT_W-1:0] W_HI = {1'b0, {(WEIGHT_W-1){1'b1}}};
   localparam logic signed [WEIGHT_W-1:0] W_LO = -W_HI;
   localparam logic signed [WEIGHT_W-1:0] STEP = WEIGHT_W'(1);

   logic agree;
   assign agree = (ref_neg == err_neg);

   always_ff @(posedge clk) begin
      if (rst) begin
         w <= '0;
      end else if (upd) begin
         if (agree) begin
            if (w != W_HI) w <= w + STEP;
         end else begin
            if (w != W_LO) w <= w - STEP;
         end
      end
   end

   p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !upd |=> $stable(w));
   p_unit_step_r4: assert property (@(posedge clk) disable iff (rst)
      upd |=> ((w == $past(w) + STEP) || (w == $past(w) - STEP)
               || ($past(w) == W_HI) || ($past(w) == W_LO)));

   always_ff @(posedge clk) begin
      if (!rst) begin
         p_bound_r6: assert (w <= W_HI && w >= W_LO);
      end
   end
endmodule

// File: rtl/qs_therm_enc.sv
`timescale 1ns/1ps
module qs_therm_enc #(
   parameter int WEIGHT_W = 10,
   localparam int THERM_W = (1 << (WEIGHT_W - 1)) - 1
) (
   input  logic signed [WEIGHT_W-1:0] w,
   output logic [THERM_W-1:0]         therm,
   output logic                       neg
);
   logic [WEIGHT_W-1:0] mag;

   assign neg = w[WEIGHT_W-1];
   assign mag = neg ? $unsigned(-w) : $unsigned(w);

   generate
      for (genvar k = 0; k < THERM_W; k++) begin : g_unit
         assign therm[k] = (mag > WEIGHT_W'(k));
      end
   endgenerate
endmodule

// File: rtl/qsslms_canceller.sv
`timescale 1ns/1ps
module qsslms_canceller #(
   parameter int SAMPLE_RATE = 2400,
   parameter int REF_W       = 8,
   parameter int WEIGHT_W    = 10,
   localparam int DELAY_LEN  = qsslms_pkg::quarter_len(SAMPLE_RATE),
   localparam int THERM_W    = qsslms_pkg::weight_limit(WEIGHT_W)
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       enable,
   input  logic                       sample_en,
   input  logic                       shift_evt,
   input  logic                       shift_up,
   input  logic                       cm_shift,
   input  logic                       out_neg,
   output logic                       ref_i_neg,
   output logic                       ref_q_neg,
   output logic signed [WEIGHT_W-1:0] w_i,
   output logic signed [WEIGHT_W-1:0] w_q,
   output logic [THERM_W-1:0]         therm_i,
   output logic [THERM_W-1:0]         therm_q,
   output logic                       sign_i,
   output logic                       sign_q,
   output logic                       dm_shift_i,
   output logic                       dm_shift_q
);
   generate
      if (SAMPLE_RATE < qsslms_pkg::QUARTER_DIV ||
          SAMPLE_RATE % qsslms_pkg::QUARTER_DIV != 0) begin : g_bad_rate
         $error("SAMPLE_RATE must be a positive multiple of 240");
      end
      if (REF_W < 2) begin : g_bad_ref
         $error("REF_W must be at least 2");
      end
      if (WEIGHT_W < 2 || WEIGHT_W > 12) begin : g_bad_weight
         $error("WEIGHT_W must lie in 2..12");
      end
   endgenerate

   logic upd;
   assign upd = sample_en & enable;

   qs_ref_track #(.REF_W(REF_W)) u_track (
      .clk       (clk),
      .rst       (rst),
      .shift_evt (shift_evt),
      .shift_up  (shift_up),
      .ref_neg   (ref_i_neg)
   );

   qs_quarter_delay #(.LEN(DELAY_LEN)) u_delay (
      .clk       (clk),
      .rst       (rst),
      .sample_en (sample_en),
      .din       (ref_i_neg),
      .dout      (ref_q_neg)
   );

   logic [1:0]                refs;
   logic signed [WEIGHT_W-1:0] w_v   [2];
   logic [THERM_W-1:0]         th_v  [2];
   logic [1:0]                 neg_v;

   assign refs = {ref_q_neg, ref_i_neg};

   generate
      for (genvar p = 0; p < 2; p++) begin : g_phase
         qs_sign_weight #(.WEIGHT_W(WEIGHT_W)) u_weight (
            .clk     (clk),
            .rst     (rst),
            .upd     (upd),
            .ref_neg (refs[p]),
            .err_neg (out_neg),
            .w       (w_v[p])
         );
         qs_therm_enc #(.WEIGHT_W(WEIGHT_W)) u_therm (
            .w     (w_v[p]),
            .therm (th_v[p]),
            .neg   (neg_v[p])
         );
      end
   endgenerate

   assign w_i        = w_v[0];
   assign w_q        = w_v[1];
   assign therm_i    = th_v[0];
   assign therm_q    = th_v[1];
   assign sign_i     = neg_v[0];
   assign sign_q     = neg_v[1];
   assign dm_shift_i = cm_shift ^ sign_i;
   assign dm_shift_q = cm_shift ^ sign_q;

   p_therm_shape_r9: assert property (@(posedge clk) disable iff (rst)
      (((therm_i + 1'b1) & therm_i) == '0) && (((therm_q + 1'b1) & therm_q) == '0));
   p_therm_count_r9: assert property (@(posedge clk) disable iff (rst)
      $countones(therm_i) == (w_i < 0 ? -int'(w_i) : int'(w_i)));
   p_reset_r1: assert property (@(posedge clk)
      rst |=> (w_i == '0 && w_q == '0 && !ref_i_neg && !ref_q_neg));
endmodule

// File: tb/qsslms_canceller_bench.sv
`timescale 1ns/1ps
module qsslms_canceller_bench;
   localparam int B_RATE = 960;
   localparam int B_RW   = 4;
   localparam int B_WW   = 5;
   localparam int B_L    = B_RATE / 240;
   localparam int B_WMAX = (1 << (B_WW - 1)) - 1;
   localparam int B_TW   = B_WMAX;
   localparam int C_MAX  = (1 << (B_RW - 1)) - 1;
   localparam int C_MIN  = -(1 << (B_RW - 1));

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic enable = 1'b0, sample_en = 1'b0, shift_evt = 1'b0, shift_up = 1'b0;
   logic cm_shift = 1'b0, out_neg = 1'b0;
   logic ref_i_neg, ref_q_neg, sign_i, sign_q, dm_shift_i, dm_shift_q;
   logic signed [B_WW-1:0] w_i, w_q;
   logic [B_TW-1:0] therm_i, therm_q;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   int exp_cnt = 0;
   int exp_wi  = 0;
   int exp_wq  = 0;
   bit exp_line [B_L];

   always #2.5 clk = ~clk;

   qsslms_canceller #(.SAMPLE_RATE(B_RATE), .REF_W(B_RW), .WEIGHT_W(B_WW)) u_qsslms_canceller (
      .clk(clk), .rst(rst), .enable(enable), .sample_en(sample_en),
      .shift_evt(shift_evt), .shift_up(shift_up), .cm_shift(cm_shift), .out_neg(out_neg),
      .ref_i_neg(ref_i_neg), .ref_q_neg(ref_q_neg), .w_i(w_i), .w_q(w_q),
      .therm_i(therm_i), .therm_q(therm_q), .sign_i(sign_i), .sign_q(sign_q),
      .dm_shift_i(dm_shift_i), .dm_shift_q(dm_shift_q)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int therm_of(input int w);
      int m = (w < 0) ? -w : w;
      int r = 0;
      for (int k = 0; k < m; k++) r |= (1 << k);
      return r;
   endfunction

   function automatic int sat(input int v);
      if (v > B_WMAX) return B_WMAX;
      if (v < -B_WMAX) return -B_WMAX;
      return v;
   endfunction

   task automatic check_weights();
      chk("R4 w_i", int'(w_i), exp_wi);
      chk("R5 w_q", int'(w_q), exp_wq);
      chk("R9 therm_i", int'(therm_i), therm_of(exp_wi));
      chk("R9 therm_q", int'(therm_q), therm_of(exp_wq));
      chk("R9 sign_i", int'(sign_i), int'(exp_wi < 0));
      chk("R9 sign_q", int'(sign_q), int'(exp_wq < 0));
   endtask

   task automatic shift(input bit up);
      @(negedge clk);
      shift_evt = 1'b1; shift_up = up;
      @(negedge clk);
      shift_evt = 1'b0;
      if (up && exp_cnt < C_MAX) exp_cnt++;
      else if (!up && exp_cnt > C_MIN) exp_cnt--;
   endtask

   task automatic do_sample(input bit o);
      bit ri = (exp_cnt < 0);
      bit rq = exp_line[B_L-1];
      @(negedge clk);
      sample_en = 1'b1; out_neg = o;
      @(negedge clk);
      sample_en = 1'b0;
      if (enable) begin
         exp_wi = sat(exp_wi + ((ri == o) ? 1 : -1));
         exp_wq = sat(exp_wq + ((rq == o) ? 1 : -1));
      end
      for (int k = B_L - 1; k > 0; k--) exp_line[k] = exp_line[k-1];
      exp_line[0] = ri;
      chk("R3 ref_q_neg", int'(ref_q_neg), int'(exp_line[B_L-1]));
      chk("R2 ref_i_neg", int'(ref_i_neg), int'(exp_cnt < 0));
      check_weights();
   endtask

   task automatic flip_ref();
      if (exp_cnt >= 0) begin
         for (int k = exp_cnt; k >= 0; k--) shift(1'b0);
      end else begin
         for (int k = exp_cnt; k < 0; k++) shift(1'b1);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 w_i", int'(w_i), 0);
      chk("R1 w_q", int'(w_q), 0);
      chk("R1 therm", int'(therm_i | therm_q), 0);
      chk("R1 signs", int'({sign_i, sign_q}), 0);
      chk("R1 refs", int'({ref_i_neg, ref_q_neg}), 0);
   endtask

   task automatic t_ref_clamp();
      shift(1'b0);
      chk("R2 one down", int'(ref_i_neg), 1);
      shift(1'b1);
      chk("R2 back up", int'(ref_i_neg), 0);
      for (int k = 0; k < 10; k++) shift(1'b1);
      chk("R2 top clamp", int'(ref_i_neg), 0);
      for (int k = 0; k < 8; k++) shift(1'b0);
      chk("R2 from max", int'(ref_i_neg), 1);
      for (int k = 0; k < 9; k++) shift(1'b0);
      chk("R2 bottom clamp", int'(ref_i_neg), 1);
      for (int k = 0; k < 8; k++) shift(1'b1);
      chk("R2 from min", int'(ref_i_neg), 0);
      shift(1'b0);
      chk("R2 cross zero", int'(ref_i_neg), 1);
   endtask

   task automatic t_delay();
      enable = 1'b0;
      for (int s = 0; s < 14; s++) begin
         if (s % 3 == 0) flip_ref();
         do_sample(s[0]);
      end
   endtask

   task automatic t_lms();
      enable = 1'b1;
      for (int s = 0; s < 16; s++) begin
         if (s % 5 == 0) flip_ref();
         do_sample(s[1] ^ s[2]);
      end
   endtask

   task automatic t_sat();
      enable = 1'b1;
      for (int s = 0; s < 40; s++) do_sample(exp_cnt < 0);
      chk("R6 upper limit", int'(w_i), B_WMAX);
      for (int s = 0; s < 40; s++) do_sample(exp_cnt >= 0);
      chk("R6 lower limit", int'(w_i), -B_WMAX);
      chk("R9 full therm", int'(therm_i), therm_of(B_WMAX));
   endtask

   task automatic t_freeze();
      int wi0 = exp_wi;
      enable = 1'b0;
      for (int s = 0; s < 6; s++) do_sample(s[0]);
      chk("R7 w_i frozen", int'(w_i), wi0);
      enable = 1'b1;
   endtask

   task automatic t_idle();
      int wi0 = exp_wi;
      int wq0 = exp_wq;
      for (int c = 0; c < 10; c++) begin
         @(negedge clk);
         out_neg = c[0]; cm_shift = c[1];
      end
      flip_ref();
      @(negedge clk);
      chk("R8 w_i idle", int'(w_i), wi0);
      chk("R8 w_q idle", int'(w_q), wq0);
   endtask

   task automatic t_dm();
      for (int c = 0; c < 2; c++) begin
         @(negedge clk);
         cm_shift = c[0];
         #1;
         chk("R10 dm_i", int'(dm_shift_i), int'(c[0] ^ (exp_wi < 0)));
         chk("R10 dm_q", int'(dm_shift_q), int'(c[0] ^ (exp_wq < 0)));
      end
      // move I weight positive to see the other polarity
      for (int s = 0; s < 20; s++) do_sample(exp_cnt < 0);
      for (int c = 0; c < 2; c++) begin
         @(negedge clk);
         cm_shift = c[0];
         #1;
         chk("R10 dm_i pos", int'(dm_shift_i), int'(c[0] ^ (exp_wi < 0)));
      end
   endtask

   initial begin
      for (int k = 0; k < B_L; k++) exp_line[k] = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_ref_clamp();
      t_delay();
      t_lms();
      t_sat();
      t_freeze();
      t_idle();
      t_dm();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule